// File: doc/BRIEF.md
# Low-Power Wake and Reset Sequencer

This block runs in the always-on domain and decides when the main power domain is powered, held in reset, and allowed to run. It watches an active-low external reset pin, a low-voltage reset input and a wake interrupt request, all asynchronous. It also takes a stop-request strobe from the main domain. From these inputs it drives the main-domain supply enable, the main-domain reset and a run enable, and it reports the operating mode.

Any exit from the deep-stop state restarts the main domain through the full power-up path. The supply comes on first. The reset stays asserted until a power-good delay has run out and every reset source has cleared. A CPU-wait delay then passes before run is granted. When the reset releases, the block samples a boot-strap pin to choose single-boot or normal start, and it drives that pin's internal pull-up only until the choice is made. A keep flag tells the always-on logic that the oscillator control register and the two reset-flag registers must survive the main reset that follows a wake. The block records which sources caused each wake in sticky cause bits, and software clears these with a write-one-to-clear strobe.

Top module: `lpw_wake_seq`

## Requirements
- R1: The pin, low-voltage, interrupt and boot inputs each pass a two-flop synchronizer. A low on the reset pin counts as a reset only after INIT_CYC consecutive synchronized low cycles, so shorter low pulses have no effect.
- R2: After the always-on reset, the mode is startup and the main reset is held low. The block leaves startup only after a qualified pin reset has been seen and the pin has returned high.
- R3: Whenever the supply enable rises, the main reset is still low. The main reset is never high while the supply enable is low.
- R4: After a deep-stop exit, when the reset sources have already cleared, the main reset releases exactly PGOOD_CYC+1 cycles after the supply enable rises. If a source has not cleared, the reset stays held until the pin is high and the low-voltage input is low.
- R5: Run enable and the normal mode appear exactly CPUWAIT_CYC cycles after the main reset releases.
- R6: When the main reset releases, single_boot_o becomes the inverse of the synchronized boot pin, so a low boot pin selects single boot. The value holds until the next release. The pull-up enable is high while the main reset is held and goes low when the reset releases.
- R7: A stop_req_i strobe in normal mode enters deep stop on the next cycle, with the supply off, the main reset low and run off. A stop request given in any other mode is ignored.
- R8: In deep stop, a qualified pin reset, a high low-voltage input or a high interrupt request ends the stop and starts the power-up. An interrupt request outside deep stop has no effect.
- R9: A qualified pin reset or a low-voltage reset in normal mode or during the CPU wait asserts the main reset and run off while the supply stays on. The block then repeats the power-up path.
- R10: keep_aon_o goes to 1 on a deep-stop exit. It goes to 0 after the always-on reset and after any reset taken outside deep stop.
- R11: wake_cause_o bit 0 records the pin, bit 1 the low-voltage input and bit 2 the interrupt. A bit is set for each source active at a deep-stop exit and stays set until its flag_clr_i bit is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R12: mode_o encodes startup or reset as 2'b00, normal as 2'b01 and deep stop as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Always-on power-on reset, active low |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| lvd_rst_i | input | 1 | Low-voltage reset request, asynchronous |
| wake_irq_i | input | 1 | Wake interrupt request, asynchronous |
| boot_pin_i | input | 1 | Boot-strap pin level, low selects single boot |
| stop_req_i | input | 1 | Single-cycle request to enter deep stop |
| flag_clr_i | input | 3 | Write-one-to-clear strobes for the wake-cause bits |
| main_pwr_en_o | output | 1 | Main power-domain supply enable |
| main_rst_no | output | 1 | Main-domain reset, active low |
| run_en_o | output | 1 | CPU run enable |
| mode_o | output | 2 | Operating mode |
| single_boot_o | output | 1 | Single-boot mode selected at the last release |
| boot_pu_en_o | output | 1 | Internal pull-up enable for the boot-strap pin |
| keep_aon_o | output | 1 | Retained always-on registers must survive the current reset |
| wake_cause_o | output | 3 | Sticky wake-cause bits |

## Verification
The assertions assume that stop_req_i and flag_clr_i are synchronous to clk_i and last a single cycle. They also assume that the asynchronous inputs hold each level for several cycles, so the synchronizers carry every pulse through. The stimulus changes inputs only on falling clock edges and holds interrupt and low-voltage pulses for at least three cycles. It keeps pin reset pulses either well under or well over INIT_CYC, and it sets the boot pin long before any release.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [2:0] {
        ST_COLD,
        ST_PWRUP,
        ST_HOLD,
        ST_CPUWAIT,
        ST_NORMAL,
        ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_START = 2'b00,
        MODE_RUN   = 2'b01,
        MODE_STOP  = 2'b10
    } op_mode_e;

    localparam int CAUSE_PIN = 0;
    localparam int CAUSE_LVD = 1;
    localparam int CAUSE_IRQ = 2;
    localparam int CAUSE_W   = 3;

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= RST_VAL;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lpw_low_qual.sv
module lpw_low_qual #(
    parameter int INIT_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic low_i,
    output logic valid_o
);

    localparam int QW = $clog2(INIT_CYC + 1);
    localparam logic [QW-1:0] LIMIT = QW'(INIT_CYC);

    logic [QW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!low_i)              cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + QW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign valid_o = (cnt_q == LIMIT);

endmodule

// File: rtl/lpw_wake_seq.sv
module lpw_wake_seq
    import lpw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INIT_CYC    = 16,
    parameter int PGOOD_CYC   = 8,
    parameter int CPUWAIT_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ext_rst_ni,
    input  logic       lvd_rst_i,
    input  logic       wake_irq_i,
    input  logic       boot_pin_i,
    input  logic       stop_req_i,
    input  logic [2:0] flag_clr_i,
    output logic       main_pwr_en_o,
    output logic       main_rst_no,
    output logic       run_en_o,
    output logic [1:0] mode_o,
    output logic       single_boot_o,
    output logic       boot_pu_en_o,
    output logic       keep_aon_o,
    output logic [2:0] wake_cause_o
);

    localparam int MAX_CYC = (PGOOD_CYC > CPUWAIT_CYC) ? PGOOD_CYC : CPUWAIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PG_LAST = CNT_W'(PGOOD_CYC - 1);
    localparam logic [CNT_W-1:0] CW_LAST = CNT_W'(CPUWAIT_CYC - 1);

    typedef struct packed {
        seq_state_e           st;
        logic [CNT_W-1:0]     cnt;
        logic                 single_boot;
        logic                 keep;
        logic [CAUSE_W-1:0]   cause;
    } seq_s;

    // synchronized inputs: bit0 pin (active low), bit1 lvd, bit2 irq, bit3 boot
    logic [3:0] raw_in, sync_q;
    logic       pin_low_s, lvd_s, irq_s, boot_s, pin_ok;

    assign raw_in = {boot_pin_i, wake_irq_i, lvd_rst_i, ext_rst_ni};

    lpw_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in),
        .q_o    (sync_q)
    );

    assign pin_low_s = ~sync_q[0];
    assign lvd_s     = sync_q[1];
    assign irq_s     = sync_q[2];
    assign boot_s    = sync_q[3];

    lpw_low_qual #(
        .INIT_CYC (INIT_CYC)
    ) qual_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .low_i   (pin_low_s),
        .valid_o (pin_ok)
    );

    seq_s cur_q, nxt_d;
    logic rst_src;
    logic [CAUSE_W-1:0] cause_set;

    always_comb begin
        nxt_d     = cur_q;
        rst_src   = pin_ok | lvd_s;
        cause_set = '0;
        unique case (cur_q.st)
            ST_COLD: begin
                if (pin_ok) begin
                    nxt_d.st   = ST_PWRUP;
                    nxt_d.cnt  = '0;
                    nxt_d.keep = 1'b0;
                end
            end
            ST_PWRUP: begin
                if (cur_q.cnt == PG_LAST) nxt_d.st  = ST_HOLD;
                else                      nxt_d.cnt = cur_q.cnt + CNT_W'(1);
            end
            ST_HOLD: begin
                if (!pin_low_s && !lvd_s) begin
                    nxt_d.st          = ST_CPUWAIT;
                    nxt_d.cnt         = '0;
                    nxt_d.single_boot = ~boot_s;
                end
            end
            ST_CPUWAIT: begin
                if (rst_src) begin
                    nxt_d.st   = ST_PWRUP;
                    nxt_d.cnt  = '0;
                    nxt_d.keep = 1'b0;
                end else if (cur_q.cnt == CW_LAST) begin
                    nxt_d.st = ST_NORMAL;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_NORMAL: begin
                if (rst_src) begin
                    nxt_d.st   = ST_PWRUP;
                    nxt_d.cnt  = '0;
                    nxt_d.keep = 1'b0;
                end else if (stop_req_i) begin
                    nxt_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (rst_src || irq_s) begin
                    nxt_d.st   = ST_PWRUP;
                    nxt_d.cnt  = '0;
                    nxt_d.keep = 1'b1;
                    cause_set[CAUSE_PIN] = pin_ok;
                    cause_set[CAUSE_LVD] = lvd_s;
                    cause_set[CAUSE_IRQ] = irq_s;
                end
            end
            default: nxt_d.st = ST_COLD;
        endcase
        nxt_d.cause = (cur_q.cause & ~flag_clr_i) | cause_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.st          <= ST_COLD;
            cur_q.cnt         <= '0;
            cur_q.single_boot <= 1'b0;
            cur_q.keep        <= 1'b0;
            cur_q.cause       <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    op_mode_e mode_e;

    always_comb begin
        case (cur_q.st)
            ST_NORMAL: mode_e = MODE_RUN;
            ST_STOP:   mode_e = MODE_STOP;
            default:   mode_e = MODE_START;
        endcase
    end

    assign mode_o        = mode_e;
    assign main_pwr_en_o = (cur_q.st != ST_STOP);
    assign main_rst_no   = (cur_q.st == ST_CPUWAIT) || (cur_q.st == ST_NORMAL);
    assign run_en_o      = (cur_q.st == ST_NORMAL);
    assign boot_pu_en_o  = (cur_q.st == ST_COLD) || (cur_q.st == ST_PWRUP) ||
                           (cur_q.st == ST_HOLD);
    assign single_boot_o = cur_q.single_boot;
    assign keep_aon_o    = cur_q.keep;
    assign wake_cause_o  = cur_q.cause;

endmodule

// File: rtl/lpw_wake_seq_chk.sv
module lpw_wake_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       stop_req_i,
    input logic [2:0] flag_clr_i,
    input logic       main_pwr_en_o,
    input logic       main_rst_no,
    input logic       run_en_o,
    input logic [1:0] mode_o,
    input logic       boot_pu_en_o,
    input logic       single_boot_o,
    input logic       keep_aon_o,
    input logic [2:0] wake_cause_o
);

    // R3: supply comes up while the main reset is still held
    p_pwr_before_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(main_pwr_en_o) |-> !main_rst_no);

    // R3 / R6: release only after a powered cycle with the pull-up active
    p_release_after_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(main_rst_no) |-> ($past(main_pwr_en_o) && $past(boot_pu_en_o) && !boot_pu_en_o));

    // R6: boot choice stays fixed while out of reset
    p_boot_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (main_rst_no && $past(main_rst_no)) |-> $stable(single_boot_o));

    // R7: deep stop is entered only from normal mode on a request
    p_stop_from_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(main_pwr_en_o) |-> ($past(run_en_o) && $past(stop_req_i) && mode_o == 2'b10));

    // R7: stop request outside normal mode has no effect
    p_stop_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_req_i && !run_en_o && mode_o != 2'b10) |=> (mode_o != 2'b10));

    // R10: every supply re-enable after a stop is a retained wake
    p_wake_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(main_pwr_en_o) && $past(mode_o) == 2'b10) |-> keep_aon_o);

    // R11: cause bits stay set unless cleared by their strobe
    p_cause_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wake_cause_o & $past(wake_cause_o & ~flag_clr_i)) == $past(wake_cause_o & ~flag_clr_i)));

    // R5 / R12: run enable only in normal mode with reset released
    p_run_mode_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_en_o) |-> ($past(main_rst_no) && mode_o == 2'b01));

endmodule

bind lpw_wake_seq lpw_wake_seq_chk chk_i (.*);

// File: tb/lpw_wake_seq_tb.sv
module lpw_wake_seq_tb_top;

    localparam int INIT_CYC    = 16;
    localparam int PGOOD_CYC   = 8;
    localparam int CPUWAIT_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ext_rst_ni = 1'b1;
    logic       lvd_rst_i = 1'b0;
    logic       wake_irq_i = 1'b0;
    logic       boot_pin_i = 1'b1;
    logic       stop_req_i = 1'b0;
    logic [2:0] flag_clr_i = 3'b000;
    logic       main_pwr_en_o, main_rst_no, run_en_o, single_boot_o;
    logic       boot_pu_en_o, keep_aon_o;
    logic [1:0] mode_o;
    logic [2:0] wake_cause_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [2:0] cause_m = 3'b000;

    always #2 clk = ~clk;

    lpw_wake_seq #(
        .SYNC_STAGES (2),
        .INIT_CYC    (INIT_CYC),
        .PGOOD_CYC   (PGOOD_CYC),
        .CPUWAIT_CYC (CPUWAIT_CYC)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .ext_rst_ni    (ext_rst_ni),
        .lvd_rst_i     (lvd_rst_i),
        .wake_irq_i    (wake_irq_i),
        .boot_pin_i    (boot_pin_i),
        .stop_req_i    (stop_req_i),
        .flag_clr_i    (flag_clr_i),
        .main_pwr_en_o (main_pwr_en_o),
        .main_rst_no   (main_rst_no),
        .run_en_o      (run_en_o),
        .mode_o        (mode_o),
        .single_boot_o (single_boot_o),
        .boot_pu_en_o  (boot_pu_en_o),
        .keep_aon_o    (keep_aon_o),
        .wake_cause_o  (wake_cause_o)
    );

    function automatic logic [2:0] next_cause(logic [2:0] c, logic [2:0] set, logic [2:0] clr);
        return (c & ~clr) | set;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run();
        int t = 0;
        while (!run_en_o && t < 400) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pin_pulse(input int n);
        ext_rst_ni = 1'b0;
        tick(n);
        ext_rst_ni = 1'b1;
    endtask

    task automatic lvd_pulse(input int n);
        lvd_rst_i = 1'b1;
        tick(n);
        lvd_rst_i = 1'b0;
    endtask

    task automatic irq_pulse(input int n);
        wake_irq_i = 1'b1;
        tick(n);
        wake_irq_i = 1'b0;
    endtask

    task automatic enter_stop();
        stop_req_i = 1'b1;
        tick(1);
        stop_req_i = 1'b0;
        check("R7", "mode after stop request", mode_o, 2'b10);
        check("R7", "supply off in stop", main_pwr_en_o, 0);
        check("R7", "main reset low in stop", main_rst_no, 0);
    endtask

    // follows a wake: from supply rise to run enable
    task automatic follow_wake(input bit exact);
        int t = 0;
        int n = 0;
        while (!main_pwr_en_o && t < 300) begin
            @(negedge clk);
            t++;
        end
        check("R8", "stop exited", main_pwr_en_o, 1);
        check("R3", "reset held at supply rise", main_rst_no, 0);
        check("R10", "keep after wake", keep_aon_o, 1);
        check("R6", "pull-up on in reset", boot_pu_en_o, 1);
        while (!main_rst_no && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (exact) check("R4", "power-good delay", n, PGOOD_CYC + 1);
        else       check("R4", "power-good at least", (n >= PGOOD_CYC + 1) ? 1 : 0, 1);
        check("R6", "pull-up off at release", boot_pu_en_o, 0);
        n = 0;
        while (!run_en_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R5", "cpu wait delay", n, CPUWAIT_CYC);
        check("R12", "normal mode code", mode_o, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        // reset state
        check("R12", "startup mode code", mode_o, 2'b00);
        check("R2", "main reset held at reset", main_rst_no, 0);
        check("R6", "pull-up on at reset", boot_pu_en_o, 1);
        check("R11", "cause clear at reset", wake_cause_o, 0);
        rst_ni = 1'b1;
        tick(20);
        check("R2", "stays in startup without pin reset", main_rst_no, 0);
        // cold start with single boot
        boot_pin_i = 1'b0;
        pin_pulse(30);
        wait_run();
        check("R2", "run after cold start", run_en_o, 1);
        check("R6", "single boot from low pin", single_boot_o, 1);
        check("R10", "no keep after cold start", keep_aon_o, 0);
        boot_pin_i = 1'b1;

        // interrupt in normal ignored
        irq_pulse(5);
        tick(10);
        check("R8", "irq in normal ignored", run_en_o, 1);
        check("R8", "irq in normal keeps reset off", main_rst_no, 1);

        // short pin pulse ignored
        pin_pulse(4);
        tick(30);
        check("R1", "short pin pulse ignored", main_rst_no, 1);

        // long pin reset in normal
        ext_rst_ni = 1'b0;
        tick(25);
        check("R9", "pin reset asserts main reset", main_rst_no, 0);
        check("R9", "supply stays on", main_pwr_en_o, 1);
        check("R1", "qualified pin reset", run_en_o, 0);
        ext_rst_ni = 1'b1;
        wait_run();
        check("R9", "run again after pin reset", run_en_o, 1);
        check("R6", "normal boot from high pin", single_boot_o, 0);
        check("R10", "no keep after pin reset", keep_aon_o, 0);

        // lvd reset in normal
        lvd_pulse(6);
        tick(1);
        check("R9", "lvd reset asserts main reset", main_rst_no, 0);
        wait_run();
        check("R9", "run again after lvd", run_en_o, 1);

        // stop request in cpu wait ignored
        ext_rst_ni = 1'b0;
        tick(25);
        ext_rst_ni = 1'b1;
        while (!main_rst_no) tick(1);
        stop_req_i = 1'b1;
        tick(1);
        stop_req_i = 1'b0;
        check("R7", "stop request in cpu wait ignored", mode_o, 2'b00);
        wait_run();
        check("R7", "normal after ignored stop", mode_o, 2'b01);

        // set wins over clear on the same cycle
        enter_stop();
        flag_clr_i = 3'b100;
        fork
            irq_pulse(3);
            begin
                while (!main_pwr_en_o) tick(1);
                flag_clr_i = 3'b000;
            end
        join
        cause_m = next_cause(cause_m, 3'b100, 3'b100);
        wait_run();
        check("R11", "set wins over clear", wake_cause_o, cause_m);

        // random wakes
        for (int it = 0; it < 40; it++) begin
            int src = $urandom % 3;
            boot_pin_i = $urandom % 2;
            if ($urandom % 2) begin
                logic [2:0] clr = 3'($urandom);
                flag_clr_i = clr;
                tick(1);
                flag_clr_i = 3'b000;
                cause_m = next_cause(cause_m, 3'b000, clr);
                check("R11", "cause after clear", wake_cause_o, cause_m);
            end
            tick(2);
            enter_stop();
            tick($urandom % 8);
            if ($urandom % 2) begin
                stop_req_i = 1'b1;
                tick(1);
                stop_req_i = 1'b0;
                check("R7", "stop request in stop ignored", mode_o, 2'b10);
            end
            irq_pulse(0);
            case (src)
                0: begin
                    fork pin_pulse(30); follow_wake(1'b0); join
                    cause_m = next_cause(cause_m, 3'b001, 3'b000);
                end
                1: begin
                    fork lvd_pulse(3); follow_wake(1'b1); join
                    cause_m = next_cause(cause_m, 3'b010, 3'b000);
                end
                default: begin
                    fork irq_pulse(3); follow_wake(1'b1); join
                    cause_m = next_cause(cause_m, 3'b100, 3'b000);
                end
            endcase
            check("R11", "cause after wake", wake_cause_o, cause_m);
            check("R6", "boot choice after wake", single_boot_o, boot_pin_i ? 0 : 1);
            check("R10", "keep persists into normal", keep_aon_o, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule